// File: doc/BRIEF.md
# PS/2 Keyboard Serial Link Engine

This block is the serial engine that sits between a keyboard controller's host logic and the two open-drain wires of a PS/2 keyboard port. The keyboard always generates the clock. The engine receives 11-bit frames. It checks the start bit, the odd parity and the stop bit. Each good byte goes to the host logic through a valid/ready pair. Frames that fail a check are dropped. A parity failure or a frame that stalls part way through is reported on a status flag.

To send a byte, the engine first pulls the clock wire low for a programmable inhibit time. It then drives a start bit, releases the clock and places the next bit on the data wire after every falling edge that the keyboard produces. The transfer ends when the keyboard acknowledges by pulling the data wire low on the eleventh clock. A transfer that is not acknowledged, or that is not finished within a cycle budget, raises a transmit timeout flag.

Both wires pass through a synchronizer and a glitch filter before they are used. A keyboard-lock input blocks reception. Outputs are pull-low enables: a 1 means "drive the wire low".

Top module: `kbl_link`

## Requirements
- R1: A received frame (start 0, data bits least-significant first, parity, stop 1) with an odd number of ones across the data and parity bits appears on rx_data_o with rx_valid_o high.
- R2: A frame whose data and parity bits hold an even number of ones is dropped and sets parity_err_o. The flag is cleared when the next good byte is delivered.
- R3: A frame whose stop bit reads 0 is dropped without delivering a byte and without changing parity_err_o or rx_tmo_o.
- R4: If a frame is not finished within RX_TMO_CYC system cycles after its start edge, it is dropped and rx_tmo_o is set. The receiver returns to idle, and the next good byte clears the flag.
- R5: While rx_valid_o is high and rx_ready_i is low, rx_valid_o and rx_data_o hold steady. The clock wire is also held low (kclk_oe_o = 1) so that the keyboard cannot send more.
- R6: While kb_lock_i is high, no byte is delivered. A frame that is in progress when kb_lock_i rises is discarded.
- R7: tx_ready_o is high only when both paths are idle and no received byte is pending. After a byte is accepted, the clock wire is held low for exactly INHIBIT_CYC cycles.
- R8: After the inhibit time, the engine drives the data wire low (start bit) and releases the clock. After each keyboard falling edge it presents, in turn, D0 to D7, the odd parity bit and then a released line (stop bit).
- R9: If the data wire is low at the eleventh falling edge (acknowledge), the transfer completes without a flag and tx_ready_o returns high. tx_ready_o stays low for the whole transfer.
- R10: If the data wire is high at the eleventh falling edge, tx_tmo_o is set.
- R11: If a transfer has not finished within TX_TMO_CYC cycles of acceptance, tx_tmo_o is set, both wires are released and tx_ready_o returns high. Accepting the next byte clears tx_tmo_o.
- R12: Low pulses on the clock wire shorter than FILT_LEN system cycles have no effect on reception.
- R13: After reset, rx_valid_o, all three flags and both pull-low enables are 0, and tx_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than the keyboard clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kclk_i | input | 1 | Level sensed on the keyboard clock wire |
| kdat_i | input | 1 | Level sensed on the keyboard data wire |
| kclk_oe_o | output | 1 | 1 pulls the clock wire low |
| kdat_oe_o | output | 1 | 1 pulls the data wire low |
| kb_lock_i | input | 1 | Keyboard lock: 1 blocks reception |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte is available |
| rx_ready_i | input | 1 | Host takes the received byte |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Host offers a byte to send |
| tx_ready_o | output | 1 | Engine accepts a byte this cycle |
| parity_err_o | output | 1 | Last dropped frame failed parity |
| rx_tmo_o | output | 1 | A frame stalled past the receive limit |
| tx_tmo_o | output | 1 | A transfer timed out or was not acknowledged |

## Verification
The receive path is driven by a table of bytes: all zeros, all ones, alternating patterns and single set bits. Each byte is sent with either the correct or an inverted parity bit. This separates bit-order mistakes from parity-sense mistakes, and it shows whether the error flag is cleared by the next good byte. The receive path is also given a bad stop bit, a truncated frame, glitches on the clock wire while the data wire is low, and frames during and across the lock.

The transmit path is served by a keyboard model that records the data wire at the end of each clock-low phase and counts the inhibit cycles. This detects a wrong bit order, a wrong parity sense or a wrong inhibit length. It is also run with no acknowledge and with a silent keyboard, to separate the two causes of the transmit timeout flag.

// File: rtl/kbl_pkg.sv
package kbl_pkg;

  localparam int FRAME_BITS = 11;
  localparam int LAST_IDX   = FRAME_BITS - 1;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_INHIB = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;

  function automatic logic odd_par(input logic [7:0] d);
    return ~^d;
  endfunction

endpackage

// File: rtl/kbl_line_filter.sv
module kbl_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   lvl_q, lvl_d;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_comb begin
    cnt_d = '0;
    lvl_d = lvl_q;
    if (synced != lvl_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        lvl_d = synced;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
      lvl_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
    end
  end

  assign level_o = lvl_q;

endmodule

// File: rtl/kbl_rx.sv
module kbl_rx
  import kbl_pkg::*;
#(
  parameter int RX_TMO_CYC = 24000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       fall_i,
  input  logic       dat_i,
  input  logic       rdy_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       perr_o,
  output logic       tmo_o,
  output logic       busy_o
);
  localparam int TW = $clog2(RX_TMO_CYC + 1);

  logic [3:0]    bitcnt_q, bitcnt_d;
  logic [8:0]    sr_q, sr_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [7:0]    data_q, data_d;
  logic          valid_q, valid_d;
  logic          perr_q, perr_d;
  logic          tmo_q, tmo_d;

  always_comb begin
    bitcnt_d = bitcnt_q;
    sr_d     = sr_q;
    tmr_d    = tmr_q;
    data_d   = data_q;
    valid_d  = valid_q;
    perr_d   = perr_q;
    tmo_d    = tmo_q;

    if (valid_q && rdy_i) valid_d = 1'b0;

    if (!en_i) begin
      bitcnt_d = '0;
      tmr_d    = '0;
    end else if (bitcnt_q != '0 && tmr_q == TW'(RX_TMO_CYC - 1)) begin
      bitcnt_d = '0;
      tmr_d    = '0;
      tmo_d    = 1'b1;
    end else begin
      if (bitcnt_q != '0) tmr_d = tmr_q + 1'b1;
      if (fall_i && !valid_q) begin
        if (bitcnt_q == '0) begin
          if (!dat_i) begin
            bitcnt_d = 4'd1;
            tmr_d    = '0;
          end
        end else if (bitcnt_q == 4'(LAST_IDX)) begin
          bitcnt_d = '0;
          tmr_d    = '0;
          if (dat_i) begin
            if (^sr_q) begin
              data_d  = sr_q[7:0];
              valid_d = 1'b1;
              perr_d  = 1'b0;
              tmo_d   = 1'b0;
            end else begin
              perr_d  = 1'b1;
            end
          end
        end else begin
          sr_d     = {dat_i, sr_q[8:1]};
          bitcnt_d = bitcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt_q <= '0;
      sr_q     <= '0;
      tmr_q    <= '0;
      data_q   <= '0;
      valid_q  <= 1'b0;
      perr_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      bitcnt_q <= bitcnt_d;
      sr_q     <= sr_d;
      tmr_q    <= tmr_d;
      data_q   <= data_d;
      valid_q  <= valid_d;
      perr_q   <= perr_d;
      tmo_q    <= tmo_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign perr_o  = perr_q;
  assign tmo_o   = tmo_q;
  assign busy_o  = (bitcnt_q != '0);

endmodule

// File: rtl/kbl_tx.sv
module kbl_tx
  import kbl_pkg::*;
#(
  parameter int INHIBIT_CYC = 1200,
  parameter int TX_TMO_CYC  = 180000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       allow_i,
  input  logic       fall_i,
  input  logic       dat_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       clk_oe_o,
  output logic       dat_oe_o,
  output logic       busy_o,
  output logic       tmo_o
);
  localparam int TW = $clog2(TX_TMO_CYC + 1);

  tx_state_e     st_q, st_d;
  logic [9:0]    sh_q, sh_d;
  logic          out_q, out_d;
  logic [3:0]    nfall_q, nfall_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmo_q, tmo_d;

  assign ready_o = (st_q == TX_IDLE) && allow_i;

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    out_d   = out_q;
    nfall_d = nfall_q;
    tmr_d   = tmr_q;
    tmo_d   = tmo_q;

    unique case (st_q)
      TX_IDLE: begin
        out_d = 1'b1;
        if (valid_i && ready_o) begin
          st_d    = TX_INHIB;
          sh_d    = {1'b1, odd_par(data_i), data_i};
          out_d   = 1'b0;
          nfall_d = '0;
          tmr_d   = '0;
          tmo_d   = 1'b0;
        end
      end
      TX_INHIB: begin
        tmr_d = tmr_q + 1'b1;
        if (tmr_q == TW'(INHIBIT_CYC - 1)) st_d = TX_SHIFT;
      end
      TX_SHIFT: begin
        tmr_d = tmr_q + 1'b1;
        if (fall_i) begin
          nfall_d = nfall_q + 1'b1;
          if (nfall_q == 4'(LAST_IDX)) begin
            st_d  = TX_IDLE;
            out_d = 1'b1;
            if (dat_i) tmo_d = 1'b1;
          end else begin
            out_d = sh_q[0];
            sh_d  = {1'b1, sh_q[9:1]};
          end
        end
      end
      default: st_d = TX_IDLE;
    endcase

    if (st_q != TX_IDLE && tmr_q == TW'(TX_TMO_CYC - 1)) begin
      st_d  = TX_IDLE;
      out_d = 1'b1;
      tmo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TX_IDLE;
      sh_q    <= '1;
      out_q   <= 1'b1;
      nfall_q <= '0;
      tmr_q   <= '0;
      tmo_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      out_q   <= out_d;
      nfall_q <= nfall_d;
      tmr_q   <= tmr_d;
      tmo_q   <= tmo_d;
    end
  end

  assign clk_oe_o = (st_q == TX_INHIB);
  assign dat_oe_o = (st_q == TX_SHIFT) && !out_q;
  assign busy_o   = (st_q != TX_IDLE);
  assign tmo_o    = tmo_q;

endmodule

// File: rtl/kbl_link.sv
module kbl_link #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int INHIBIT_CYC = 1200,
  parameter int RX_TMO_CYC  = 24000,
  parameter int TX_TMO_CYC  = 180000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kclk_i,
  input  logic       kdat_i,
  output logic       kclk_oe_o,
  output logic       kdat_oe_o,
  input  logic       kb_lock_i,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  input  logic       rx_ready_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic       parity_err_o,
  output logic       rx_tmo_o,
  output logic       tx_tmo_o
);
  localparam int NLINES = 2;

  logic [1:0]        rsync_q;
  logic              srst_n;
  logic [NLINES-1:0] raw, lvl;
  logic              clk_prev_q, kfall;
  logic              rx_busy, rx_valid, tx_busy, tx_clk_oe, tx_dat_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  assign raw = {kdat_i, kclk_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    kbl_line_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
    ) u_filt (
      .clk     (clk),
      .rst_n   (srst_n),
      .line_i  (raw[g]),
      .level_o (lvl[g])
    );
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) clk_prev_q <= 1'b1;
    else         clk_prev_q <= lvl[0];
  end
  assign kfall = clk_prev_q && !lvl[0];

  kbl_rx #(
    .RX_TMO_CYC (RX_TMO_CYC)
  ) u_rx (
    .clk     (clk),
    .rst_n   (srst_n),
    .en_i    (!tx_busy && !kb_lock_i),
    .fall_i  (kfall),
    .dat_i   (lvl[1]),
    .rdy_i   (rx_ready_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid),
    .perr_o  (parity_err_o),
    .tmo_o   (rx_tmo_o),
    .busy_o  (rx_busy)
  );

  kbl_tx #(
    .INHIBIT_CYC (INHIBIT_CYC),
    .TX_TMO_CYC  (TX_TMO_CYC)
  ) u_tx (
    .clk      (clk),
    .rst_n    (srst_n),
    .allow_i  (srst_n && !rx_busy && !rx_valid),
    .fall_i   (kfall),
    .dat_i    (lvl[1]),
    .data_i   (tx_data_i),
    .valid_i  (tx_valid_i),
    .ready_o  (tx_ready_o),
    .clk_oe_o (tx_clk_oe),
    .dat_oe_o (tx_dat_oe),
    .busy_o   (tx_busy),
    .tmo_o    (tx_tmo_o)
  );

  assign rx_valid_o = rx_valid;
  assign kclk_oe_o  = tx_clk_oe || rx_valid;
  assign kdat_oe_o  = tx_dat_oe;

endmodule

// File: rtl/kbl_link_chk.sv
module kbl_link_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       kclk_oe_o,
  input logic       kdat_oe_o,
  input logic       kb_lock_i,
  input logic [7:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic       parity_err_o,
  input logic       rx_tmo_o,
  input logic       tx_tmo_o
);

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o)); // R5

  AST_PEND_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> kclk_oe_o); // R5

  AST_GOOD_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> !parity_err_o && !rx_tmo_o); // R2

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    kb_lock_i && !rx_valid_o |=> !rx_valid_o); // R6

  AST_READY_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> !rx_valid_o); // R7

  AST_ACCEPT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_i && tx_ready_o |=> kclk_oe_o && !tx_ready_o && !tx_tmo_o); // R7

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> !kclk_oe_o && !kdat_oe_o); // R11

  AST_TMO_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_tmo_o) |-> tx_ready_o); // R11

endmodule

bind kbl_link kbl_link_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .kclk_oe_o    (kclk_oe_o),
  .kdat_oe_o    (kdat_oe_o),
  .kb_lock_i    (kb_lock_i),
  .rx_data_o    (rx_data_o),
  .rx_valid_o   (rx_valid_o),
  .rx_ready_i   (rx_ready_i),
  .tx_valid_i   (tx_valid_i),
  .tx_ready_o   (tx_ready_o),
  .parity_err_o (parity_err_o),
  .rx_tmo_o     (rx_tmo_o),
  .tx_tmo_o     (tx_tmo_o)
);

// File: tb/sim_kbl_link.sv
module sim_kbl_link;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 20;
  localparam int INH        = 100;
  localparam int RXT        = 800;
  localparam int TXT        = 3000;
  localparam int FL         = 4;
  localparam int NVEC       = 6;
  // {flip parity, data}
  localparam logic [8:0] RXV [NVEC] = '{
    {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b1, 8'h81},
    {1'b0, 8'h5A}, {1'b0, 8'h3C}, {1'b1, 8'h01}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, kb_clk_low, kb_dat_low, kb_lock, rx_ready, tx_valid;
  logic [7:0] tx_data;
  logic       kclk_oe, kdat_oe, rx_valid, tx_ready, perr, rx_tmo, tx_tmo;
  logic [7:0] rx_data;
  wire        kclk_line = ~(kb_clk_low | kclk_oe);
  wire        kdat_line = ~(kb_dat_low | kdat_oe);

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 1'b0;

  kbl_link #(
    .SYNC_STAGES (2), .FILT_LEN (FL), .INHIBIT_CYC (INH),
    .RX_TMO_CYC (RXT), .TX_TMO_CYC (TXT)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .kclk_i (kclk_line), .kdat_i (kdat_line),
    .kclk_oe_o (kclk_oe), .kdat_oe_o (kdat_oe), .kb_lock_i (kb_lock),
    .rx_data_o (rx_data), .rx_valid_o (rx_valid), .rx_ready_i (rx_ready),
    .tx_data_i (tx_data), .tx_valid_i (tx_valid), .tx_ready_o (tx_ready),
    .parity_err_o (perr), .rx_tmo_o (rx_tmo), .tx_tmo_o (tx_tmo)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kb_frame(input logic [7:0] d, input logic flip, input logic stop, input int nbits);
    logic [10:0] f;
    f = {stop, (~^d) ^ flip, d, 1'b0};
    for (int i = 0; i < nbits; i++) begin
      kb_dat_low = ~f[i];
      wait_n(HALF);
      kb_clk_low = 1'b1;
      wait_n(HALF);
      kb_clk_low = 1'b0;
    end
    wait_n(HALF);
    kb_dat_low = 1'b0;
    wait_n(HALF);
  endtask

  task automatic host_read();
    rx_ready = 1'b1;
    wait_n(1);
    rx_ready = 1'b0;
    wait_n(3 * HALF);
  endtask

  task automatic tx_start(input logic [7:0] d);
    tx_data  = d;
    tx_valid = 1'b1;
    wait_n(1);
    tx_valid = 1'b0;
  endtask

  task automatic kb_serve(input logic ack, output logic [10:0] bits, output int inh, output int busy_rdy);
    inh = 0;
    busy_rdy = 0;
    while (kclk_oe) begin
      inh++;
      if (tx_ready) busy_rdy++;
      wait_n(1);
    end
    bits = '0;
    bits[0] = kdat_line;
    wait_n(HALF);
    for (int p = 1; p <= 10; p++) begin
      kb_clk_low = 1'b1;
      wait_n(HALF);
      bits[p] = kdat_line;
      if (tx_ready) busy_rdy++;
      kb_clk_low = 1'b0;
      wait_n(HALF);
    end
    if (ack) kb_dat_low = 1'b1;
    wait_n(2);
    kb_clk_low = 1'b1;
    wait_n(HALF);
    kb_clk_low = 1'b0;
    wait_n(HALF);
    kb_dat_low = 1'b0;
    wait_n(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [10:0] bits;
    int          inh, brdy;
    rst_n = 1'b0; kb_clk_low = 1'b0; kb_dat_low = 1'b0; kb_lock = 1'b0;
    rx_ready = 1'b0; tx_valid = 1'b0; tx_data = '0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(10);

    // R13 reset state
    chk("R13 rx_valid", rx_valid, 0);
    chk("R13 flags", {perr, rx_tmo, tx_tmo}, 0);
    chk("R13 pull enables", {kclk_oe, kdat_oe}, 0);
    chk("R13 tx_ready", tx_ready, 1);

    // R1 / R2 table of receive vectors
    for (int i = 0; i < NVEC; i++) begin
      kb_frame(RXV[i][7:0], RXV[i][8], 1'b1, 11);
      if (!RXV[i][8]) begin
        chk("R1 valid", rx_valid, 1);
        chk("R1 data", rx_data, RXV[i][7:0]);
        chk("R2 parity flag clear", perr, 0);
        chk("R5 clock held while pending", kclk_oe, 1);
        chk("R7 no tx while pending", tx_ready, 0);
        host_read();
        chk("R5 released after read", {rx_valid, kclk_oe}, 0);
      end else begin
        chk("R2 bad frame dropped", rx_valid, 0);
        chk("R2 parity flag set", perr, 1);
      end
    end

    // R12 glitches on clock while data low, then a good byte
    kb_dat_low = 1'b1;
    for (int g = 0; g < 3; g++) begin
      kb_clk_low = 1'b1;
      wait_n(FL - 2);
      kb_clk_low = 1'b0;
      wait_n(HALF);
    end
    kb_dat_low = 1'b0;
    wait_n(HALF);
    kb_frame(8'hC3, 1'b0, 1'b1, 11);
    chk("R12 byte after glitches", {rx_valid, rx_data}, {1'b1, 8'hC3});
    chk("R2 flag cleared by good byte", perr, 0);
    host_read();

    // R3 stop bit low
    kb_frame(8'h77, 1'b0, 1'b0, 11);
    chk("R3 bad stop dropped", rx_valid, 0);
    chk("R3 flags unchanged", {perr, rx_tmo}, 0);

    // R4 receive timeout
    kb_frame(8'h12, 1'b0, 1'b1, 4);
    wait_n(RXT + 50);
    chk("R4 rx timeout flag", rx_tmo, 1);
    chk("R4 no byte", rx_valid, 0);
    kb_frame(8'h34, 1'b0, 1'b1, 11);
    chk("R4 recover byte", {rx_valid, rx_data}, {1'b1, 8'h34});
    chk("R4 flag cleared", rx_tmo, 0);
    host_read();

    // R6 lock
    kb_lock = 1'b1;
    kb_frame(8'h55, 1'b0, 1'b1, 11);
    chk("R6 locked frame ignored", rx_valid, 0);
    kb_lock = 1'b0;
    kb_frame(8'h0F, 1'b0, 1'b1, 3);
    kb_lock = 1'b1;
    wait_n(50);
    kb_lock = 1'b0;
    wait_n(HALF);
    kb_frame(8'h66, 1'b0, 1'b1, 11);
    chk("R6 partial discarded", {rx_valid, rx_data}, {1'b1, 8'h66});
    host_read();

    // R7 R8 R9 transmit with acknowledge
    chk("R7 ready before tx", tx_ready, 1);
    tx_start(8'hA5);
    kb_serve(1'b1, bits, inh, brdy);
    chk("R7 inhibit length", inh, INH);
    chk("R8 frame bits", bits, {1'b1, ~^8'hA5, 8'hA5, 1'b0});
    chk("R9 ready low during transfer", brdy, 0);
    chk("R9 done no flag", {tx_ready, tx_tmo}, 2'b10);

    // R10 missing acknowledge
    tx_start(8'h3C);
    kb_serve(1'b0, bits, inh, brdy);
    chk("R8 frame bits 3C", bits, {1'b1, ~^8'h3C, 8'h3C, 1'b0});
    chk("R10 no ack flag", {tx_ready, tx_tmo}, 2'b11);

    // R11 silent keyboard
    tx_start(8'h11);
    chk("R11 flag cleared on accept", tx_tmo, 0);
    wait_n(TXT + 50);
    chk("R11 timeout flag", tx_tmo, 1);
    chk("R11 wires released", {kclk_oe, kdat_oe}, 0);
    chk("R11 ready again", tx_ready, 1);
    tx_start(8'h22);
    chk("R11 cleared by next accept", tx_tmo, 0);
    kb_serve(1'b1, bits, inh, brdy);
    chk("R9 second byte ok", {tx_ready, tx_tmo, bits[8:1]}, {2'b10, 8'h22});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule